// File: doc/BRIEF.md
# Display Adapter Status and Port Base Selector

This block sits on the I/O bus of a PC-compatible display adapter and owns the few registers that decide where the adapter answers and which operating mode it is in. A software-written base-select bit in the miscellaneous output register decides whether the CRTC index port, the CRTC data port and the input status port appear in the colour window (0x3Dx) or the monochrome window (0x3Bx). The block drives select lines for the CRTC index and data ports; the CRTC register file behind them lives elsewhere.

A read of the input status port returns a retrace indication whose encoding depends on the current adapter mode. The read also emits a one-cycle pulse that returns the attribute controller's index/data toggle to its index state. A pair of monochrome graphics card registers is also held here: an enable register and a mode control register. Mode control can switch between monochrome text and monochrome graphics, and can select a display page, but only while the matching enable bit is set. Entering monochrome operation through mode control clears the base-select bit, so the CRTC ports move to the monochrome window.

The adapter mode is a three-state machine. States: `MODE_COLOR` (code 0), `MODE_MONO_TEXT` (code 1, the reset state) and `MODE_MONO_GFX` (code 2). Transitions:
- `T_MISC_TO_COLOR`: a misc write with bit 0 set, from any state, goes to `MODE_COLOR`.
- `T_MISC_TO_MONO`: a misc write with bit 0 clear goes from `MODE_COLOR` to `MODE_MONO_TEXT`. In either mono state the machine stays where it is.
- `T_MCTL_TEXT`: a mode control write with bit 1 clear, while enable bit 0 is set, goes from any state to `MODE_MONO_TEXT`.
- `T_MCTL_GFX`: the same write with bit 1 set goes from any state to `MODE_MONO_GFX`.

Top module: `adapter_port_select`

## Requirements
- R1: With misc bit 0 set, `crtc_index_sel` is high only for address 0x3D4, `crtc_data_sel` only for 0x3D5, and the status port is claimed only at 0x3DA. With misc bit 0 clear, the same ports are 0x3B4, 0x3B5 and 0x3BA. The inactive window never selects or claims.
- R2: A write to 0x3C2 stores the 8-bit misc value. A read of 0x3CC returns that value with `rd_claim` high.
- R3: A read of the active status port returns 0x81 during retrace in `MODE_MONO_GFX`, and 0x09 during retrace in the other modes. With retrace low it returns 0x00.
- R4: `attr_ff_clear` pulses high in the cycle after each cycle in which the active status port is read. It stays low after reads of any other address, including the inactive status port.
- R5: A write to 0x3BF stores the enable bits. While enable bit 0 is set, a write to 0x3B8 selects `MODE_MONO_GFX` (data bit 1 set) or `MODE_MONO_TEXT` (bit 1 clear). While enable bit 0 is clear, a 0x3B8 write leaves `adapter_mode` unchanged.
- R6: While enable bit 1 is set, a write to 0x3B8 loads `disp_page` from data bit 7. While it is clear, `disp_page` holds.
- R7: A 0x3B8 write that takes effect under enable bit 0 clears misc bit 0, which is visible at 0x3CC and moves the CRTC ports to 0x3Bx.
- R8: A read of 0x3B8 returns 0x00 with `rd_claim` high. A read of an address the block does not own returns 0xFF with `rd_claim` low.
- R9: After reset, `adapter_mode` is 1 (`MODE_MONO_TEXT`), misc is 0x00 (monochrome window), the enable bits are clear and `disp_page` is 0.
- R10: `adapter_mode` follows the misc transitions `T_MISC_TO_COLOR` and `T_MISC_TO_MONO`. A misc write with bit 0 clear leaves `MODE_MONO_GFX` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| retrace | input | 1 | Retrace in progress, from the timing generator |
| rd_data | output | 8 | Read data, valid in the cycle of `io_rd` |
| rd_claim | output | 1 | The block owns the address being read |
| crtc_index_sel | output | 1 | Address is the CRTC index port in the active window |
| crtc_data_sel | output | 1 | Address is the CRTC data port in the active window |
| attr_ff_clear | output | 1 | One-cycle pulse returning the attribute index/data toggle to index |
| adapter_mode | output | 2 | Current mode: 0 colour, 1 mono text, 2 mono graphics |
| disp_page | output | 1 | Selected monochrome display page |

## Verification
The bench builds the block with its default 16-bit address and the standard port addresses. In both base settings it sweeps every address from 0x3B0 to 0x3DF, which reaches each port's decode and read result along with the boundary between the two windows. It also reads the status port for every combination of mode and retrace. Finally, it runs all four enable combinations against mode control values with bits 1 and 7 in every pairing, so both gates are exercised with and without effect.

// File: rtl/adapter_port_select_pkg.sv
package adapter_port_select_pkg;

    typedef enum logic [1:0] {
        MODE_COLOR     = 2'd0,
        MODE_MONO_TEXT = 2'd1,
        MODE_MONO_GFX  = 2'd2
    } adapter_mode_e;

    localparam int DATA_W = 8;

endpackage

// File: rtl/aps_port_decode.sv
module aps_port_decode #(
    parameter int              ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] COLOR_BASE = 16'h03D0,
    parameter logic [ADDR_W-1:0] MONO_BASE  = 16'h03B0,
    parameter logic [ADDR_W-1:0] MISC_WADDR = 16'h03C2,
    parameter logic [ADDR_W-1:0] MISC_RADDR = 16'h03CC,
    parameter logic [ADDR_W-1:0] MCTL_ADDR  = 16'h03B8,
    parameter logic [ADDR_W-1:0] ENBL_ADDR  = 16'h03BF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              color_base,
    output logic              index_sel,
    output logic              data_sel,
    output logic              status_sel,
    output logic              misc_w_sel,
    output logic              misc_r_sel,
    output logic              mctl_sel,
    output logic              enbl_sel
);
    localparam logic [ADDR_W-1:0] OFS_INDEX  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_DATA   = ADDR_W'(5);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(10);
    localparam int NWIN = 2;

    logic [NWIN-1:0] win_index, win_data, win_status;

    // One decoder per window; the base bit picks which one is live.
    for (genvar w = 0; w < NWIN; w++) begin : g_window
        localparam logic [ADDR_W-1:0] BASE = (w == 1) ? COLOR_BASE : MONO_BASE;
        assign win_index[w]  = (addr == BASE + OFS_INDEX);
        assign win_data[w]   = (addr == BASE + OFS_DATA);
        assign win_status[w] = (addr == BASE + OFS_STATUS);
    end

    always_comb begin
        index_sel  = color_base ? win_index[1]  : win_index[0];
        data_sel   = color_base ? win_data[1]   : win_data[0];
        status_sel = color_base ? win_status[1] : win_status[0];
        misc_w_sel = (addr == MISC_WADDR);
        misc_r_sel = (addr == MISC_RADDR);
        mctl_sel   = (addr == MCTL_ADDR);
        enbl_sel   = (addr == ENBL_ADDR);
    end
endmodule

// File: rtl/aps_mode_fsm.sv
module aps_mode_fsm
    import adapter_port_select_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          misc_wr,
    input  logic          mctl_wr,
    input  logic          enbl_wr,
    input  logic [DW-1:0] wdata,
    output adapter_mode_e mode,
    output logic [DW-1:0] misc_q,
    output logic [DW-1:0] enbl_q,
    output logic          page_q
);
    localparam int BIT_BASE  = 0;
    localparam int BIT_GFX   = 1;
    localparam int BIT_PAGE  = DW - 1;
    localparam int EN_MODE   = 0;
    localparam int EN_PAGE   = 1;

    adapter_mode_e state_q, state_d;
    logic [DW-1:0] misc_d, enbl_d;
    logic          page_d;
    logic          mctl_mode_go;

    assign mctl_mode_go = mctl_wr && enbl_q[EN_MODE];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_MONO_TEXT;
            misc_q  <= '0;
            enbl_q  <= '0;
            page_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            misc_q  <= misc_d;
            enbl_q  <= enbl_d;
            page_q  <= page_d;
        end
    end

    // Next state and register updates
    always_comb begin
        state_d = state_q;
        misc_d  = misc_q;
        enbl_d  = enbl_q;
        page_d  = page_q;
        unique case (state_q)
            MODE_COLOR: begin
                if (mctl_mode_go)
                    state_d = wdata[BIT_GFX] ? MODE_MONO_GFX : MODE_MONO_TEXT;
                else if (misc_wr && !wdata[BIT_BASE])
                    state_d = MODE_MONO_TEXT;
            end
            MODE_MONO_TEXT, MODE_MONO_GFX: begin
                if (mctl_mode_go)
                    state_d = wdata[BIT_GFX] ? MODE_MONO_GFX : MODE_MONO_TEXT;
                else if (misc_wr && wdata[BIT_BASE])
                    state_d = MODE_COLOR;
            end
            default: state_d = MODE_MONO_TEXT;
        endcase
        if (misc_wr)
            misc_d = wdata;
        if (mctl_mode_go)
            misc_d[BIT_BASE] = 1'b0;
        if (enbl_wr)
            enbl_d = wdata;
        if (mctl_wr && enbl_q[EN_PAGE])
            page_d = wdata[BIT_PAGE];
    end

    // Outputs
    always_comb begin
        mode = state_q;
    end
endmodule

// File: rtl/aps_status_mux.sv
module aps_status_mux
    import adapter_port_select_pkg::*;
#(
    parameter int          DW          = DATA_W,
    parameter logic [DW-1:0] RETRACE_STD = 8'h09,
    parameter logic [DW-1:0] RETRACE_GFX = 8'h81,
    parameter logic [DW-1:0] IDLE_CODE   = 8'h00,
    parameter logic [DW-1:0] FLOAT_CODE  = 8'hFF
) (
    input  adapter_mode_e mode,
    input  logic          retrace,
    input  logic          status_sel,
    input  logic          misc_r_sel,
    input  logic          mctl_sel,
    input  logic [DW-1:0] misc_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_claim
);
    logic [DW-1:0] status_byte;

    always_comb begin
        if (!retrace)
            status_byte = IDLE_CODE;
        else if (mode == MODE_MONO_GFX)
            status_byte = RETRACE_GFX;
        else
            status_byte = RETRACE_STD;
    end

    always_comb begin
        rd_claim = 1'b1;
        if (status_sel)
            rd_data = status_byte;
        else if (misc_r_sel)
            rd_data = misc_q;
        else if (mctl_sel)
            rd_data = '0;
        else begin
            rd_data  = FLOAT_CODE;
            rd_claim = 1'b0;
        end
    end
endmodule

// File: rtl/adapter_port_select.sv
module adapter_port_select
    import adapter_port_select_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    input  logic              retrace,
    output logic [7:0]        rd_data,
    output logic              rd_claim,
    output logic              crtc_index_sel,
    output logic              crtc_data_sel,
    output logic              attr_ff_clear,
    output logic [1:0]        adapter_mode,
    output logic              disp_page
);
    logic          status_sel, misc_w_sel, misc_r_sel, mctl_sel, enbl_sel;
    logic [7:0]    misc_q, enbl_q;
    adapter_mode_e mode;
    logic          attr_clr_q;

    aps_port_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr       (io_addr),
        .color_base (misc_q[0]),
        .index_sel  (crtc_index_sel),
        .data_sel   (crtc_data_sel),
        .status_sel (status_sel),
        .misc_w_sel (misc_w_sel),
        .misc_r_sel (misc_r_sel),
        .mctl_sel   (mctl_sel),
        .enbl_sel   (enbl_sel)
    );

    aps_mode_fsm #(.DW(8)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .misc_wr (io_wr && misc_w_sel),
        .mctl_wr (io_wr && mctl_sel),
        .enbl_wr (io_wr && enbl_sel),
        .wdata   (io_wdata),
        .mode    (mode),
        .misc_q  (misc_q),
        .enbl_q  (enbl_q),
        .page_q  (disp_page)
    );

    aps_status_mux #(.DW(8)) u_status (
        .mode       (mode),
        .retrace    (retrace),
        .status_sel (status_sel),
        .misc_r_sel (misc_r_sel),
        .mctl_sel   (mctl_sel),
        .misc_q     (misc_q),
        .rd_data    (rd_data),
        .rd_claim   (rd_claim)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) attr_clr_q <= 1'b0;
        else        attr_clr_q <= io_rd && status_sel;
    end

    assign attr_ff_clear = attr_clr_q;
    assign adapter_mode  = mode;
endmodule

// File: rtl/adapter_port_select_checker.sv
module adapter_port_select_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] io_addr,
    input logic        io_wr,
    input logic        io_rd,
    input logic        retrace,
    input logic [7:0]  rd_data,
    input logic        crtc_index_sel,
    input logic        crtc_data_sel,
    input logic        status_sel,
    input logic        attr_ff_clear,
    input logic [1:0]  adapter_mode,
    input logic        disp_page,
    input logic [7:0]  misc_q,
    input logic [7:0]  enbl_q
);
    p_decode_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({crtc_index_sel, crtc_data_sel, status_sel}));

    p_idle_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && status_sel && !retrace) |-> (rd_data == 8'h00));

    p_attr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && status_sel) |=> attr_ff_clear);

    p_attr_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && status_sel) |=> !attr_ff_clear);

    p_mode_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == 16'h03B8 && !enbl_q[0]) |=> $stable(adapter_mode));

    p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && io_addr == 16'h03B8 && enbl_q[1]) |=> $stable(disp_page));

    p_base_matches_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (adapter_mode == 2'd0) == misc_q[0]);
endmodule

bind adapter_port_select adapter_port_select_checker u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .io_addr        (io_addr),
    .io_wr          (io_wr),
    .io_rd          (io_rd),
    .retrace        (retrace),
    .rd_data        (rd_data),
    .crtc_index_sel (crtc_index_sel),
    .crtc_data_sel  (crtc_data_sel),
    .status_sel     (status_sel),
    .attr_ff_clear  (attr_ff_clear),
    .adapter_mode   (adapter_mode),
    .disp_page      (disp_page),
    .misc_q         (misc_q),
    .enbl_q         (enbl_q)
);

// File: tb/adapter_port_select_bench.sv
module adapter_port_select_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic        retrace = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_claim, crtc_index_sel, crtc_data_sel, attr_ff_clear, disp_page;
    logic [1:0]  adapter_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_misc, m_en;
    logic [1:0] m_mode;
    logic       m_page;

    always #2 clk = ~clk;

    adapter_port_select u_adapter_port_select (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .retrace(retrace), .rd_data(rd_data), .rd_claim(rd_claim),
        .crtc_index_sel(crtc_index_sel), .crtc_data_sel(crtc_data_sel),
        .attr_ff_clear(attr_ff_clear), .adapter_mode(adapter_mode), .disp_page(disp_page)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        if (a == 16'h03C2) begin
            m_misc = d;
            if (d[0]) m_mode = 2'd0;
            else if (m_mode == 2'd0) m_mode = 2'd1;
        end
        if (a == 16'h03BF) m_en = d;
        if (a == 16'h03B8) begin
            if (m_en[0]) begin
                m_mode = d[1] ? 2'd2 : 2'd1;
                m_misc[0] = 1'b0;
            end
            if (m_en[1]) m_page = d[7];
        end
    endtask

    // Read one address; returns data and claim, then the pulse seen one cycle later.
    task automatic io_read(input logic [15:0] a, output logic [7:0] d,
                           output logic c, output logic pulse);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = rd_data; c = rd_claim;
        @(negedge clk);
        io_rd = 1'b0;
        pulse = attr_ff_clear;
    endtask

    task automatic check_state(input string req);
        logic [7:0] d; logic c, p;
        check(req, {30'd0, adapter_mode}, {30'd0, m_mode});
        check(req, {31'd0, disp_page}, {31'd0, m_page});
        io_read(16'h03CC, d, c, p);
        check(req, {23'd0, c, d}, {23'd0, 1'b1, m_misc});
    endtask

    function automatic logic [7:0] status_exp(input logic [1:0] md, input logic rt);
        if (!rt) return 8'h00;
        return (md == 2'd2) ? 8'h81 : 8'h09;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic c, p;
        m_misc = 8'h00; m_en = 8'h00; m_mode = 2'd1; m_page = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        check("R9 mode", {30'd0, adapter_mode}, 32'd1);
        check("R9 page", {31'd0, disp_page}, 32'd0);
        io_read(16'h03CC, d, c, p);
        check("R9 misc", {24'd0, d}, 32'h00);
        io_addr = 16'h03B4; #1;
        check("R9 mono window", {31'd0, crtc_index_sel}, 32'd1);

        // R1 R2 R8: address sweep in both base settings
        for (int base = 0; base < 2; base++) begin
            io_write(16'h03C2, base[0] ? 8'hA7 : 8'h5A);
            for (int a = 16'h03B0; a <= 16'h03DF; a++) begin
                logic [15:0] ad;
                logic [15:0] wb;
                logic ei, ed, es, cl;
                logic [7:0] ex;
                ad = a[15:0];
                wb = base[0] ? 16'h03D0 : 16'h03B0;
                ei = (ad == wb + 16'd4);
                ed = (ad == wb + 16'd5);
                es = (ad == wb + 16'd10);
                cl = 1'b1;
                if (es) ex = status_exp(m_mode, 1'b0);
                else if (ad == 16'h03CC) ex = m_misc;
                else if (ad == 16'h03B8) ex = 8'h00;
                else begin ex = 8'hFF; cl = 1'b0; end
                @(negedge clk);
                io_addr = ad; io_rd = 1'b1;
                #1;
                check("R1 R2 R8 sweep", {ad, ei, ed, cl, 5'd0, rd_data},
                      {ad, ei, ed, cl, 5'd0, ex} ^ {16'd0, crtc_index_sel ^ ei,
                       crtc_data_sel ^ ed, rd_claim ^ cl, 13'd0});
            end
            @(negedge clk);
            io_rd = 1'b0;
        end

        // R10: misc transitions
        io_write(16'h03C2, 8'h01);
        check_state("R10 to color");
        io_write(16'h03C2, 8'h00);
        check_state("R10 to mono text");

        // R5 R6 R7: enable combinations against mode control values
        for (int en = 0; en < 4; en++) begin
            for (int v = 0; v < 4; v++) begin
                logic [7:0] mv;
                mv = {v[1], 5'd0, v[0], 1'b0};
                io_write(16'h03C2, 8'h01);
                io_write(16'h03BF, en[7:0]);
                io_write(16'h03B8, mv);
                check_state("R5 R6 R7 gate");
                io_addr = 16'h03B4; #1;
                check("R7 window", {31'd0, crtc_index_sel}, {31'd0, ~m_misc[0]});
            end
        end

        // R10: misc bit0 clear in mono graphics keeps the mode
        io_write(16'h03BF, 8'h01);
        io_write(16'h03B8, 8'h02);
        io_write(16'h03C2, 8'h00);
        check_state("R10 gfx holds");

        // R3 R4: status in each mode with and without retrace
        for (int md = 0; md < 3; md++) begin
            for (int rt = 0; rt < 2; rt++) begin
                logic [15:0] sa;
                io_write(16'h03BF, 8'h01);
                if (md == 0) io_write(16'h03C2, 8'h01);
                else io_write(16'h03B8, (md == 2) ? 8'h02 : 8'h00);
                retrace = rt[0];
                sa = (m_mode == 2'd0) ? 16'h03DA : 16'h03BA;
                io_read(sa, d, c, p);
                check("R3 status", {24'd0, d}, {24'd0, status_exp(m_mode, rt[0])});
                check("R4 pulse", {31'd0, p}, 32'd1);
                io_read(sa ^ 16'h0060, d, c, p);
                check("R4 inactive window", {23'd0, c, p, d}, {23'd0, 1'b0, 1'b0, 8'hFF});
            end
        end
        retrace = 1'b0;
        io_read(16'h03CC, d, c, p);
        check("R4 other read", {31'd0, p}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule